// File: doc/BRIEF.md
# Debug Trap Sequencer

This block sits beside an in-order retire stage and makes one decision per retired instruction: whether a debug exception must be requested, and if so which vector and which return address. It covers three sources. The first is the single-step trap, driven by the trap-enable bit of the flag image. The second is the one-byte breakpoint opcode. The third is the two-byte software interrupt, which carries an explicit vector and passes through a privilege check. It also masks single-step for one boundary after an instruction that loads the stack-segment register.

Each retire is presented for one cycle on `rt_valid`, together with the opcode byte, the operand byte, a stack-segment-load flag, the address of the next instruction, the flag image that was in effect while the instruction ran, the operating mode, CPL and IOPL. The block never stalls the retire stage, so it has no ready signal and applies no back-pressure: every retire is consumed in the cycle it is presented. Requests leave on `exc_valid` as a one-cycle pulse with no handshake. The dispatcher that receives them must accept a request in the cycle it appears.

Top module: `dbg_trap_seq`

## Requirements
- R1: During and after reset, `exc_valid` is 0, `exc_vector` is 0 and `exc_ret_addr` is 32'hFFFF_FFF0.
- R2: `exc_valid` is a one-cycle pulse registered one clock after an `rt_valid` cycle that raises an exception. There is at most one request per retire. No request appears without a retire, and a retire that raises nothing produces no request.
- R3: When bit 8 of `rt_flags` is 1 for a retiring instruction that raises nothing of its own, the block requests vector 1 with `exc_ret_addr` equal to that instruction's `rt_next_pc`.
- R4: The flag image is the one in effect before the instruction ran. An instruction that sets the trap bit (for example a return that reloads the flags) does not itself trap. The first step trap comes after exactly one later instruction.
- R5: A retire with `rt_ss_load` = 1 produces no step trap at its boundary, even when the trap bit is set. A step trap deferred from an earlier instruction stays pending across that boundary.
- R6: Opcode 8'hCC requests vector 3 with return address `rt_next_pc`, whatever the mode, CPL and IOPL.
- R7: Opcode 8'hCD requests the vector given in `rt_operand`, with return address `rt_next_pc`, in the following cases: the mode is real (`rt_mode` = 0), or CPL <= IOPL.
- R8: Opcode 8'hCD in protected mode (`rt_mode` = 1) or virtual-8086 mode (`rt_mode` = 2) with CPL > IOPL requests vector 13 instead. Its return address is `rt_next_pc` - 2, taken modulo 2^32, which is the address of the faulting instruction.
- R9: When an instruction raises its own exception while the trap bit is set, its own exception is reported and the step trap is deferred. The deferred trap is reported at the next retire that raises nothing of its own and is not a stack-segment load. It carries the stored return address.
- R10: `exc_ret_addr` and `exc_vector` hold their last values between requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rt_valid | input | 1 | One instruction retires this cycle |
| rt_opcode | input | 8 | First opcode byte of the retiring instruction |
| rt_operand | input | 8 | Second byte (vector for 8'hCD) |
| rt_ss_load | input | 1 | Retiring instruction loads the stack-segment register |
| rt_next_pc | input | 32 | Address of the next instruction |
| rt_flags | input | 32 | Flag image in effect during the instruction; bit 8 enables single step |
| rt_mode | input | 2 | 0 real, 1 protected, 2 virtual-8086, 3 treated as protected |
| rt_cpl | input | 2 | Current privilege level |
| rt_iopl | input | 2 | I/O privilege level |
| exc_valid | output | 1 | One-cycle exception request |
| exc_vector | output | 8 | Requested vector |
| exc_ret_addr | output | 32 | Return address saved with the request |

## Verification
The bench builds the block with its default parameters: 32-bit addresses and flags, the trap bit at position 8, the reset address 32'hFFFF_FFF0 and a two-byte software interrupt. The 32-bit width lets a failing software interrupt at next address 1 wrap its fault return address to 32'hFFFF_FFFF. The fixed reset value makes the R1 check exact. The scoreboard model tracks one deferred step trap, so it can follow chains of deferrals across breakpoints, stack-segment loads and back-to-back retires.

// File: rtl/dbg_trap_pkg.sv
package dbg_trap_pkg;

  typedef enum logic [1:0] {
    MODE_REAL = 2'd0,
    MODE_PROT = 2'd1,
    MODE_V86  = 2'd2,
    MODE_RSVD = 2'd3
  } cpu_mode_e;

  localparam logic [7:0] VEC_STEP = 8'd1;
  localparam logic [7:0] VEC_BRK  = 8'd3;
  localparam logic [7:0] VEC_GP   = 8'd13;

  // Privilege check for the explicit-vector software interrupt.
  function automatic logic swint_denied(input logic [1:0] mode,
                                        input logic [1:0] cpl,
                                        input logic [1:0] iopl);
    return (cpu_mode_e'(mode) != MODE_REAL) && (cpl > iopl);
  endfunction

endpackage

// File: rtl/dbg_swint_check.sv
module dbg_swint_check
  import dbg_trap_pkg::*;
#(
  parameter int          ADDR_W  = 32,
  parameter logic [7:0]  BRK_OPC = 8'hCC,
  parameter logic [7:0]  INT_OPC = 8'hCD,
  parameter int          INT_LEN = 2
) (
  input  logic [7:0]        opcode,
  input  logic [7:0]        operand,
  input  logic [1:0]        mode,
  input  logic [1:0]        cpl,
  input  logic [1:0]        iopl,
  input  logic [ADDR_W-1:0] next_pc,
  output logic              own_hit,
  output logic [7:0]        own_vec,
  output logic [ADDR_W-1:0] own_addr
);
  localparam logic [ADDR_W-1:0] LEN = ADDR_W'(INT_LEN);

  logic is_brk, is_int, denied;

  assign is_brk = (opcode == BRK_OPC);
  assign is_int = (opcode == INT_OPC);
  assign denied = swint_denied(mode, cpl, iopl);

  always_comb begin
    own_hit  = 1'b0;
    own_vec  = 8'd0;
    own_addr = next_pc;
    if (is_brk) begin
      own_hit = 1'b1;
      own_vec = VEC_BRK;
    end else if (is_int) begin
      own_hit = 1'b1;
      if (denied) begin
        own_vec  = VEC_GP;
        own_addr = next_pc - LEN;
      end else begin
        own_vec  = operand;
      end
    end
  end
endmodule

// File: rtl/dbg_step_track.sv
module dbg_step_track #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rt_valid,
  input  logic              tf,
  input  logic              ss_load,
  input  logic              own_hit,
  input  logic [ADDR_W-1:0] next_pc,
  output logic              step_hit,
  output logic [ADDR_W-1:0] step_addr
);
  logic              pend_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic              arm, report_pend, report_now;

  assign arm         = tf && !ss_load;
  assign report_pend = rt_valid && pend_q && !ss_load && !own_hit;
  assign report_now  = rt_valid && !pend_q && arm && !own_hit;
  assign step_hit    = report_pend || report_now;
  assign step_addr   = pend_q ? pend_addr_q : next_pc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
    end else if (rt_valid) begin
      if (own_hit) begin
        if (arm) begin
          pend_q      <= 1'b1;
          pend_addr_q <= next_pc;
        end
      end else if (!ss_load && pend_q) begin
        pend_q <= arm;
        if (arm) pend_addr_q <= next_pc;
      end
    end
  end

  // R9
  defer_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_valid && own_hit && arm) |=> (pend_q && pend_addr_q == $past(next_pc)));

  // R5
  ss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_valid && ss_load && !own_hit) |=> (pend_q == $past(pend_q)));
endmodule

// File: rtl/dbg_trap_seq.sv
module dbg_trap_seq
  import dbg_trap_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          FLAG_W   = 32,
  parameter int          TF_BIT   = 8,
  parameter logic [31:0] RESET_PC = 32'hFFFF_FFF0,
  parameter logic [7:0]  BRK_OPC  = 8'hCC,
  parameter logic [7:0]  INT_OPC  = 8'hCD,
  parameter int          INT_LEN  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rt_valid,
  input  logic [7:0]        rt_opcode,
  input  logic [7:0]        rt_operand,
  input  logic              rt_ss_load,
  input  logic [ADDR_W-1:0] rt_next_pc,
  input  logic [FLAG_W-1:0] rt_flags,
  input  logic [1:0]        rt_mode,
  input  logic [1:0]        rt_cpl,
  input  logic [1:0]        rt_iopl,
  output logic              exc_valid,
  output logic [7:0]        exc_vector,
  output logic [ADDR_W-1:0] exc_ret_addr
);
  localparam logic [ADDR_W-1:0] RST_ADDR = RESET_PC[ADDR_W-1:0];

  logic              own_hit, step_hit, tf, flags_unused;
  logic [7:0]        own_vec;
  logic [ADDR_W-1:0] own_addr, step_addr;
  logic              primed_q;

  assign tf           = rt_flags[TF_BIT];
  assign flags_unused = ^rt_flags;

  dbg_swint_check #(
    .ADDR_W(ADDR_W), .BRK_OPC(BRK_OPC), .INT_OPC(INT_OPC), .INT_LEN(INT_LEN)
  ) u_swint (
    .opcode(rt_opcode), .operand(rt_operand), .mode(rt_mode),
    .cpl(rt_cpl), .iopl(rt_iopl), .next_pc(rt_next_pc),
    .own_hit(own_hit), .own_vec(own_vec), .own_addr(own_addr)
  );

  dbg_step_track #(.ADDR_W(ADDR_W)) u_step (
    .clk(clk), .rst_n(rst_n), .rt_valid(rt_valid), .tf(tf),
    .ss_load(rt_ss_load), .own_hit(own_hit), .next_pc(rt_next_pc),
    .step_hit(step_hit), .step_addr(step_addr)
  );

  // Own exception of the retiring instruction outranks any step trap.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exc_valid    <= 1'b0;
      exc_vector   <= 8'd0;
      exc_ret_addr <= RST_ADDR;
      primed_q     <= 1'b0;
    end else begin
      primed_q  <= 1'b1;
      exc_valid <= rt_valid && (own_hit || step_hit);
      if (rt_valid && own_hit) begin
        exc_vector   <= own_vec;
        exc_ret_addr <= own_addr;
      end else if (rt_valid && step_hit) begin
        exc_vector   <= VEC_STEP;
        exc_ret_addr <= step_addr;
      end
    end
  end

  // R2
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && exc_valid) |-> $past(rt_valid));

  // R6
  brk_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_valid && rt_opcode == BRK_OPC) |=>
      (exc_valid && exc_vector == VEC_BRK && exc_ret_addr == $past(rt_next_pc)));

  // R8
  gp_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_valid && rt_opcode == INT_OPC && rt_mode != 2'd0 && rt_cpl > rt_iopl) |=>
      (exc_valid && exc_vector == VEC_GP &&
       exc_ret_addr == $past(rt_next_pc) - ADDR_W'(INT_LEN)));

  // R7
  swint_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_valid && rt_opcode == INT_OPC && (rt_mode == 2'd0 || rt_cpl <= rt_iopl)) |=>
      (exc_valid && exc_vector == $past(rt_operand)));

  // R5
  ss_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_valid && rt_ss_load && rt_opcode != BRK_OPC && rt_opcode != INT_OPC) |=>
      !exc_valid);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && !exc_valid) |-> $stable(exc_ret_addr));
endmodule

// File: tb/dbg_trap_seq_tb.sv
module dbg_trap_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rt_valid, rt_ss_load;
  logic [7:0]  rt_opcode, rt_operand;
  logic [31:0] rt_next_pc, rt_flags;
  logic [1:0]  rt_mode, rt_cpl, rt_iopl;
  logic        exc_valid;
  logic [7:0]  exc_vector;
  logic [31:0] exc_ret_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_trap_seq u_dut (
    .clk(clk), .rst_n(rst_n), .rt_valid(rt_valid), .rt_opcode(rt_opcode),
    .rt_operand(rt_operand), .rt_ss_load(rt_ss_load), .rt_next_pc(rt_next_pc),
    .rt_flags(rt_flags), .rt_mode(rt_mode), .rt_cpl(rt_cpl), .rt_iopl(rt_iopl),
    .exc_valid(exc_valid), .exc_vector(exc_vector), .exc_ret_addr(exc_ret_addr)
  );

  typedef struct {
    logic [7:0]  vec;
    logic [31:0] addr;
    string       req;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0;
  int          errors = 0;
  bit          running = 0;
  bit          done = 0;
  bit          m_pend = 0;
  logic [31:0] m_paddr = '0;
  logic [31:0] last_addr = 32'hFFFF_FFF0;
  logic [7:0]  last_vec = 8'd0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] v, input logic [31:0] a, input string req);
    exp_t e;
    e.vec = v; e.addr = a; e.req = req;
    sb.push_back(e);
    last_vec = v; last_addr = a;
  endtask

  // Driver: presents one retire and records what the requirements predict.
  task automatic retire(input logic [7:0] op, input logic [7:0] opd, input bit ss,
                        input logic [31:0] npc, input bit tf, input logic [1:0] mode,
                        input logic [1:0] cpl, input logic [1:0] iopl,
                        input string req);
    bit own, arm;
    logic [7:0]  ov;
    logic [31:0] oa;
    @(negedge clk);
    rt_valid = 1'b1; rt_opcode = op; rt_operand = opd; rt_ss_load = ss;
    rt_next_pc = npc; rt_flags = tf ? 32'h0000_0102 : 32'h0000_0002;
    rt_mode = mode; rt_cpl = cpl; rt_iopl = iopl;
    own = 0; ov = 0; oa = npc;
    if (op == 8'hCC) begin own = 1; ov = 8'd3; end
    else if (op == 8'hCD) begin
      own = 1;
      if (mode != 2'd0 && cpl > iopl) begin ov = 8'd13; oa = npc - 32'd2; end
      else ov = opd;
    end
    arm = tf && !ss;
    if (own) begin
      push(ov, oa, req);
      if (arm) begin m_pend = 1; m_paddr = npc; end
    end else if (ss) begin
      // masked boundary, deferred trap stays
    end else if (m_pend) begin
      push(8'd1, m_paddr, req);
      m_pend = arm;
      if (arm) m_paddr = npc;
    end else if (arm) begin
      push(8'd1, npc, req);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rt_valid = 1'b0;
    end
  endtask

  // Monitor: pops one expectation per observed request.
  always @(negedge clk) begin
    if (running && exc_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R2 unexpected request", {24'd0, exc_vector}, 32'hFFFF_FFFF);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(exc_vector == e.vec, e.req, {24'd0, exc_vector}, {24'd0, e.vec});
        check(exc_ret_addr == e.addr, e.req, exc_ret_addr, e.addr);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rt_valid = 1'b0; rt_opcode = 8'h90; rt_operand = 8'h00;
    rt_ss_load = 1'b0; rt_next_pc = '0; rt_flags = 32'h2;
    rt_mode = 2'd0; rt_cpl = 2'd0; rt_iopl = 2'd0;
    repeat (3) @(negedge clk);
    check(exc_valid == 1'b0, "R1 valid in reset", {31'd0, exc_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(exc_valid == 1'b0, "R1 valid", {31'd0, exc_valid}, 0);
    check(exc_vector == 8'd0, "R1 vector", {24'd0, exc_vector}, 0);
    check(exc_ret_addr == 32'hFFFF_FFF0, "R1 ret addr", exc_ret_addr, 32'hFFFF_FFF0);
    running = 1;

    // R2: plain instructions without the trap bit raise nothing
    retire(8'h90, 8'h00, 0, 32'h100, 0, 2'd1, 2'd0, 2'd0, "R2 quiet");
    retire(8'h89, 8'h00, 0, 32'h102, 0, 2'd1, 2'd3, 2'd0, "R2 quiet");
    // R3: single step on a plain instruction
    retire(8'h90, 8'h00, 0, 32'h200, 1, 2'd1, 2'd0, 2'd0, "R3 step");
    idle(2);
    // R4: return loads TF, first trap after one target instruction
    retire(8'hCF, 8'h00, 0, 32'h300, 0, 2'd1, 2'd0, 2'd0, "R4 iret no trap");
    retire(8'h90, 8'h00, 0, 32'h301, 1, 2'd1, 2'd0, 2'd0, "R4 first step");
    // R5: stack-segment load masks the step at its boundary
    retire(8'h8E, 8'hD0, 1, 32'h400, 1, 2'd1, 2'd0, 2'd0, "R5 ss mask");
    retire(8'h90, 8'h00, 0, 32'h402, 1, 2'd1, 2'd0, 2'd0, "R5 after ss");
    idle(1);
    // R6: breakpoint ignores privilege
    retire(8'hCC, 8'h00, 0, 32'h501, 0, 2'd1, 2'd3, 2'd0, "R6 brk prot");
    retire(8'hCC, 8'h00, 0, 32'h502, 0, 2'd2, 2'd3, 2'd0, "R6 brk v86");
    // R7: software interrupt allowed
    retire(8'hCD, 8'h21, 0, 32'h602, 0, 2'd0, 2'd3, 2'd0, "R7 real");
    retire(8'hCD, 8'h80, 0, 32'h604, 0, 2'd1, 2'd0, 2'd0, "R7 prot cpl0");
    retire(8'hCD, 8'h10, 0, 32'h606, 0, 2'd2, 2'd3, 2'd3, "R7 v86 equal");
    // R8: privilege failure, including wrap of the return address
    retire(8'hCD, 8'h21, 0, 32'h702, 0, 2'd1, 2'd3, 2'd0, "R8 prot gp");
    retire(8'hCD, 8'h21, 0, 32'h704, 0, 2'd2, 2'd1, 2'd0, "R8 v86 gp");
    retire(8'hCD, 8'h05, 0, 32'h1,   0, 2'd1, 2'd2, 2'd1, "R8 gp wrap");
    idle(1);
    // R9: own exception with TF defers the step
    retire(8'hCD, 8'h40, 0, 32'h802, 1, 2'd0, 2'd0, 2'd0, "R9 own first");
    retire(8'h90, 8'h00, 0, 32'h803, 1, 2'd0, 2'd0, 2'd0, "R9 deferred");
    retire(8'h90, 8'h00, 0, 32'h804, 0, 2'd0, 2'd0, 2'd0, "R9 re-deferred");
    retire(8'h90, 8'h00, 0, 32'h805, 0, 2'd0, 2'd0, 2'd0, "R9 quiet after");
    // R9 + R5: deferred trap survives a stack-segment load
    retire(8'hCC, 8'h00, 0, 32'h901, 1, 2'd1, 2'd0, 2'd0, "R9 brk tf");
    retire(8'h17, 8'h00, 1, 32'h902, 0, 2'd1, 2'd0, 2'd0, "R5 ss keeps pend");
    retire(8'h90, 8'h00, 0, 32'h903, 0, 2'd1, 2'd0, 2'd0, "R9 after ss");
    idle(4);
    check(sb.size() == 0, "R2 all requests seen", sb.size(), 0);
    // R10: outputs hold between requests
    check(exc_ret_addr == last_addr, "R10 ret hold", exc_ret_addr, last_addr);
    check(exc_vector == last_vec, "R10 vec hold", {24'd0, exc_vector}, {24'd0, last_vec});
    check(exc_valid == 1'b0, "R2 idle low", {31'd0, exc_valid}, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule